// File: doc/BRIEF.md
# Match-Compare Interval Timer

This block is an up-counting interval timer that a host programs through a single-cycle register port. An external tick-enable strobe stands in for a slow timebase. A selectable prescaler divides it down, and each divided tick advances the count by one while counting is enabled. The count is compared against a programmable match value. When they first become equal, the block emits a one-clock interrupt pulse. An optional auto-zero mode returns the count to zero on the divided tick that finds it at the match value.

Zeroing the counter is a posted operation. A host write to the clear register raises a pending flag. The zeroing itself happens on the next divided tick, because the counter only changes on that tick. Software polls the pending flag in the status register until it drops, and only then rearms the timer. Counting can be paused without losing the count, and reads return the live count at any moment.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads zero (match, count, control, clock select, status), and `irq` is low.
- R2: Register map on byte offsets: 0x00 match (the low CNT_W bits are stored), 0x04 count (read-only, and writes to it are ignored), 0x08 control (bits [1:0] stored), 0x0C clear (write-only, reads zero), 0x10 clock select (bits [2:0] stored), 0x14 status (read-only). Unmapped offsets read zero.
- R3: When control bit 0 (run) is set, the count advances by exactly one on each divided tick, and never in a cycle without one. Clock-select values 0, 1, 2 and 3 give one divided tick per 1, 2, 3 and 4 `tick_en` pulses. Any other value gives one per pulse.
- R4: With run cleared and no clear pending, the count holds its value whatever `tick_en` does. Setting run again resumes from that value.
- R5: The count is CNT_W bits wide and wraps from all ones to zero.
- R6: When run is set and the count equals match, `irq` pulses high for exactly one clock, one clock after the equality appears. The pulse is not repeated while the equality persists.
- R7: When control bit 1 (auto-zero) is set and a divided tick finds the count equal to match while running, the count becomes zero instead of advancing.
- R8: A write of any data to 0x0C sets status bit 10 (clear pending) from the next clock. The count keeps its value until the first divided tick after the write. On that tick the count becomes zero and bit 10 drops, whether or not run is set. A pending clear takes precedence over advancing and over auto-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Slow timebase strobe, one clock per timebase tick |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | One-clock interrupt pulse on a new match |

## Verification
The checker assumes that `tick_en` is a clean one-clock strobe sampled on `clk`, and that a write is a single clock with a stable offset. It also assumes that the clock-select value is written only while no divided tick is due. If the divider ratio changed between two strobes, the phase count would exceed the new terminal value and the first divided tick would come early. The directed tasks therefore drive `tick_en` high for one clock and low for the next, never assert `tick_en` in a write cycle, and reprogram the divider only while the strobe is low. The bench builds the timer with an 8-bit count so that wrap-around is reachable.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;
  localparam int SEL_W  = 3;
  localparam int PH_W   = 2;

  localparam logic [ADDR_W-1:0] OFS_MATCH  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLKSEL = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h14;

  localparam int STATUS_PEND_BIT = 10;

  typedef struct packed {
    logic autozero;
    logic run;
  } ctrl_t;

  // Terminal prescaler phase for a select code: ratio minus one.
  function automatic logic [PH_W-1:0] last_phase(input logic [SEL_W-1:0] sel);
    logic [PH_W-1:0] r;
    case (sel)
      3'd1:    r = 2'd1;
      3'd2:    r = 2'd2;
      3'd3:    r = 2'd3;
      default: r = 2'd0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mt_regs.sv
module mt_regs
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              pend,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [CNT_W-1:0]  match_q,
  output ctrl_t             ctrl_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              clr_req
);
  logic [BUS_W-1:0] cnt_ext;
  logic [BUS_W-1:0] match_ext;

  generate
    if (CNT_W < BUS_W) begin : g_pad
      assign cnt_ext   = {{(BUS_W-CNT_W){1'b0}}, cnt};
      assign match_ext = {{(BUS_W-CNT_W){1'b0}}, match_q};
    end else begin : g_full
      assign cnt_ext   = cnt;
      assign match_ext = match_q;
    end
  endgenerate

  assign clr_req = bus_wr && (bus_addr == OFS_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '0;
      ctrl_q  <= '0;
      sel_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_MATCH:  match_q <= bus_wdata[CNT_W-1:0];
        OFS_CTRL:   ctrl_q  <= ctrl_t'(bus_wdata[1:0]);
        OFS_CLKSEL: sel_q   <= bus_wdata[SEL_W-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_MATCH:  bus_rdata = match_ext;
      OFS_COUNT:  bus_rdata = cnt_ext;
      OFS_CTRL:   bus_rdata[1:0] = ctrl_q;
      OFS_CLKSEL: bus_rdata[SEL_W-1:0] = sel_q;
      OFS_STATUS: bus_rdata[STATUS_PEND_BIT] = pend;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mt_prescale.sv
module mt_prescale
  import mt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] sel,
  output logic             div_tick
);
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_last;

  assign ph_last  = last_phase(sel);
  assign div_tick = tick_en && (ph_q >= ph_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (tick_en) begin
      ph_q <= div_tick ? '0 : ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/mt_core.sv
module mt_core
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_tick,
  input  logic             clr_req,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] cnt,
  output logic             pend,
  output logic             hit,
  output logic             irq
);
  logic hit_d;

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c,
                                               input logic zero);
    return zero ? '0 : c + 1'b1;
  endfunction

  assign hit = ctrl.run && (cnt == match_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pend  <= 1'b0;
      hit_d <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (div_tick) begin
        if (pend)          cnt <= '0;
        else if (ctrl.run) cnt <= advance(cnt, ctrl.autozero && hit);
      end
      if (clr_req)       pend <= 1'b1;
      else if (div_tick) pend <= 1'b0;
      hit_d <= hit;
      irq   <= hit && !hit_d;
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] match_q;
  ctrl_t            ctrl_q;
  logic [SEL_W-1:0] sel_q;
  logic             clr_req;
  logic             div_tick;
  logic             pend;
  logic             hit;

  mt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt(cnt), .pend(pend), .bus_rdata(bus_rdata),
    .match_q(match_q), .ctrl_q(ctrl_q), .sel_q(sel_q), .clr_req(clr_req)
  );

  mt_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sel(sel_q),
    .div_tick(div_tick)
  );

  mt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .div_tick(div_tick), .clr_req(clr_req),
    .ctrl(ctrl_q), .match_val(match_q), .cnt(cnt), .pend(pend),
    .hit(hit), .irq(irq)
  );
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_tick,
  input logic             clr_req,
  input logic             run,
  input logic             autozero,
  input logic             hit,
  input logic             pend,
  input logic [CNT_W-1:0] cnt,
  input logic             irq
);
  assert_irq_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |=> irq);

  assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !div_tick |=> $stable(cnt));

  assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pend) |=> $stable(cnt));

  assert_step_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_tick && run && !pend && !(autozero && hit))
      |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_autozero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_tick && run && autozero && hit && !pend) |=> (cnt == '0));

  assert_pend_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> pend);

  assert_clear_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (div_tick && pend && !clr_req) |=> (cnt == '0 && !pend));
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_tick(div_tick), .clr_req(clr_req),
  .run(ctrl_q.run), .autozero(ctrl_q.autozero), .hit(hit), .pend(pend),
  .cnt(cnt), .irq(irq)
);

// File: tb/match_timer_tb.sv
module match_timer_tb;
  localparam int W = 8;
  localparam logic [7:0] A_MATCH = 8'h00, A_COUNT = 8'h04, A_CTRL = 8'h08,
                         A_CLEAR = 8'h0C, A_SEL = 8'h10, A_STAT = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_seen = 0;

  always #2.5 clk = ~clk;

  match_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_seen++;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic drain_clear();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(A_STAT, v);
      if (!v[10]) break;
      tick(1);
    end
  endtask

  task automatic rezero(input logic [2:0] sel);
    wr(A_CTRL, 0);
    wr(A_SEL, {29'd0, sel});
    wr(A_CLEAR, 32'hFFFF_0000);
    drain_clear();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_MATCH, v);  check("R1 match", v, 0);
    rd(A_COUNT, v);  check("R1 count", v, 0);
    rd(A_CTRL, v);   check("R1 ctrl", v, 0);
    rd(A_SEL, v);    check("R1 clksel", v, 0);
    rd(A_STAT, v);   check("R1 status", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_MATCH, 32'h1234_56A5); rd(A_MATCH, v); check("R2 match", v, 32'hA5);
    wr(A_CTRL, 32'hFFFF_FFFF);  rd(A_CTRL, v);  check("R2 ctrl", v, 3);
    wr(A_SEL, 32'hFF);          rd(A_SEL, v);   check("R2 clksel", v, 7);
    wr(A_COUNT, 32'h55);        rd(A_COUNT, v); check("R2 count ro", v, 0);
    rd(A_CLEAR, v);             check("R2 clear reads 0", v, 0);
    rd(8'h20, v);               check("R2 unmapped", v, 0);
    wr(A_CTRL, 0); wr(A_SEL, 0);
  endtask

  task automatic t_divide();
    logic [31:0] v;
    logic [2:0] sels [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5};
    for (int k = 0; k < 5; k++) begin
      int d;
      d = (sels[k] < 4) ? sels[k] + 1 : 1;
      rezero(sels[k]);
      wr(A_CTRL, 1);
      tick(3 * d - 1);
      rd(A_COUNT, v); check("R3 before third divided tick", v, 2);
      tick(1);
      rd(A_COUNT, v); check("R3 after third divided tick", v, 3);
    end
    repeat (10) @(negedge clk);
    rd(A_COUNT, v); check("R3 no advance without tick_en", v, 3);
  endtask

  task automatic t_wrap_and_hold();
    logic [31:0] v;
    wr(A_MATCH, 32'h0);
    rezero(0);
    wr(A_CTRL, 1);
    tick(255);
    rd(A_COUNT, v); check("R5 all ones", v, 32'hFF);
    tick(1);
    rd(A_COUNT, v); check("R5 wrap to zero", v, 0);
    tick(7);
    wr(A_CTRL, 0);
    tick(8);
    rd(A_COUNT, v); check("R4 stopped hold", v, 7);
    wr(A_CTRL, 1);
    tick(1);
    rd(A_COUNT, v); check("R4 resume", v, 8);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    int base;
    wr(A_MATCH, 5);
    rezero(0);
    wr(A_CTRL, 1);
    base = irq_seen;
    tick(4);
    check("R6 no irq before match", irq_seen - base, 0);
    tick(1);
    repeat (6) @(negedge clk);
    check("R6 single pulse on match", irq_seen - base, 1);
    tick(1);
    rd(A_COUNT, v); check("R6 count passes match", v, 6);
    check("R6 no reissue", irq_seen - base, 1);
  endtask

  task automatic t_autozero();
    logic [31:0] v;
    int base;
    wr(A_MATCH, 3);
    rezero(0);
    wr(A_CTRL, 3);
    base = irq_seen;
    tick(3);
    rd(A_COUNT, v); check("R7 at match", v, 3);
    tick(1);
    rd(A_COUNT, v); check("R7 zeroed on match", v, 0);
    tick(3);
    repeat (3) @(negedge clk);
    check("R7 second match pulse", irq_seen - base, 2);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(A_MATCH, 32'hF0);
    rezero(0);
    wr(A_CTRL, 1);
    tick(9);
    wr(A_CTRL, 0);
    wr(A_CLEAR, 32'h0);
    rd(A_STAT, v); check("R8 pending set", v, 32'h400);
    repeat (5) @(negedge clk);
    rd(A_COUNT, v); check("R8 count kept until tick", v, 9);
    rd(A_STAT, v);  check("R8 still pending", v, 32'h400);
    tick(1);
    rd(A_COUNT, v); check("R8 zeroed while stopped", v, 0);
    rd(A_STAT, v);  check("R8 pending dropped", v, 0);
    wr(A_SEL, 3);
    wr(A_CTRL, 1);
    tick(4);
    wr(A_CLEAR, 32'h1);
    tick(3);
    rd(A_STAT, v);  check("R8 pending through partial divide", v, 32'h400);
    rd(A_COUNT, v); check("R8 count kept during partial divide", v, 1);
    tick(1);
    rd(A_COUNT, v); check("R8 clear beats advance", v, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_divide();
    t_wrap_and_hold();
    t_irq();
    t_autozero();
    t_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule